// File: doc/BRIEF.md
# Nine-Bit Multidrop UART

This block is a full-duplex asynchronous serial port meant to sit behind a microcontroller's register bus. One 8-bit control/status register selects the frame format, gates the receiver, supplies the extra transmit bit and reports the extra received bit. It also holds the two completion flags. A second write target, the transmit holding byte, starts a frame. Bit timing comes from an external tick that pulses once per oversample period, OVS ticks per bit. Baud-rate generation is not part of this block.

In the nine-bit formats the extra bit can serve as an address marker on a shared line. With the multidrop filter on, a listener raises its receive flag only for frames whose extra bit is 1, so data frames meant for other nodes are not seen. Both completion flags stay set until software writes them back to zero. Their OR drives the interrupt line.

Control register fields (bit: meaning): 7:6 format select, 5 multidrop filter enable, 4 receive enable, 3 extra transmit bit, 2 extra/stop received bit, 1 transmit-done flag, 0 receive-done flag.

Top module: `uart9_port`

## Requirements
- R1: After reset, txd is 1, ctrl_q reads 0x00 and irq is 0.
- R2: A write with wr_sel=0 loads every ctrl_q field from wr_data[7:0]. A format select with bit 7 set (values 2 and 3) chooses nine-bit frames. Values 0 and 1 choose eight-bit frames.
- R3: A write with wr_sel=1 while the transmitter is idle sends one frame on txd. The frame is a 0 start bit, then wr_data LSB first, then ctrl bit 3 (nine-bit formats only), then a 1 stop bit. Each bit lasts OVS ticks.
- R4: A write with wr_sel=1 while a frame is still being sent is ignored. The frame in progress continues unchanged.
- R5: When the last bit of a transmit frame ends, ctrl bit 1 is set. It stays set until software writes it to 0. irq equals ctrl bit 1 OR ctrl bit 0.
- R6: With ctrl bit 4 set, a received frame is stored in rx_data and sets ctrl bit 0. Ctrl bit 2 takes the ninth data bit in nine-bit formats. In eight-bit formats it takes the stop bit.
- R7: With ctrl bit 4 clear, line activity on rxd leaves rx_data and ctrl bit 0 unchanged.
- R8: A start bit is checked at its middle. A low pulse on rxd that ends before that point produces no frame.
- R9: A frame that completes while ctrl bit 0 is still set is dropped. rx_data keeps the earlier byte.
- R10: With ctrl bit 5 set in a nine-bit format, a frame whose ninth bit is 0 leaves rx_data and ctrl bit 0 unchanged. A frame whose ninth bit is 1 is accepted.
- R11: With ctrl bit 5 set in an eight-bit format, a frame whose stop bit is 0 is rejected. A frame with a valid stop bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per oversample period |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 transmit byte |
| wr_data | input | DW | Write data; control uses bits 7:0 |
| ctrl_q | output | 8 | Control/status register contents |
| rx_data | output | DW | Last accepted received byte |
| irq | output | 1 | Transmit-done OR receive-done |

## Verification
The bench builds the port with its defaults, DW=8 and OVS=16, and pulses baud_tick on every fourth clock. One bit then takes 64 clocks, so an eleven-bit frame finishes in about 700 cycles. This makes it practical to cover every format, the filter cases, overrun and a false start in one short run. The 16x oversampling also puts the mid-bit start check within reach of a pulse only three ticks long.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  // bits on the line for one frame: start + data + optional ninth + stop
  function automatic int unsigned frame_len(input logic nine, input int unsigned dw);
    return dw + 2 + (nine ? 1 : 0);
  endfunction

  // multidrop acceptance: filter off passes all; on, nine-bit needs marker, eight-bit needs stop
  function automatic logic mp_pass(input logic nine, input logic mp_en,
                                   input logic bit9, input logic stop);
    if (!mp_en) return 1'b1;
    return nine ? bit9 : stop;
  endfunction

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_b9,
  input  logic          ld_nine,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(OVS);
  localparam int SW = DW + 3;
  localparam int BW = $clog2(SW + 1);

  logic [SW-1:0] sh_q;
  logic [CW-1:0] tcnt_q;
  logic [BW-1:0] left_q;
  logic          busy_q, done_q;
  logic          bit_end;
  logic          accept_load;

  assign accept_load = load && !busy_q;
  assign bit_end     = busy_q && tick && (tcnt_q == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tcnt_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_load) begin
        sh_q   <= {1'b1, (ld_nine ? ld_b9 : 1'b1), ld_data, 1'b0};
        left_q <= BW'(frame_len(ld_nine, DW));
        tcnt_q <= '0;
        busy_q <= 1'b1;
      end else if (bit_end) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[SW-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == BW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (busy_q && tick) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

  // R3
  tx_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_load |=> (!txd && busy_q));

  // R4
  tx_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy_q && !bit_end) |=> ($stable(sh_q) && busy_q));

  // R5
  tx_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q && txd));

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop
);
  localparam int CW = $clog2(OVS);
  localparam int NB = DW + 2;
  localparam int IW = $clog2(NB + 1);

  rx_state_t     state_q;
  logic [CW-1:0] tcnt_q;
  logic [IW-1:0] idx_q;
  logic [NB-1:0] bits_q;
  logic          s1_q, s2_q, done_q;
  logic          false_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  assign false_start = en && tick && (state_q == RX_START) && s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        state_q <= RX_IDLE;
      end else if (tick) begin
        case (state_q)
          RX_IDLE: if (!s2_q) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
          RX_START: begin
            if (s2_q) begin
              state_q <= RX_IDLE;
            end else if (tcnt_q == CW'(OVS / 2 - 1)) begin
              state_q <= RX_BITS;
              tcnt_q  <= '0;
              idx_q   <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_BITS: begin
            if (tcnt_q == CW'(OVS - 1)) begin
              tcnt_q        <= '0;
              bits_q[idx_q] <= s2_q;
              idx_q         <= idx_q + 1'b1;
              if (idx_q == IW'(frame_len(nine, DW) - 2)) begin
                state_q <= RX_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done = done_q;
  assign data = bits_q[DW-1:0];
  assign bit9 = bits_q[DW];
  assign stop = nine ? bits_q[DW+1] : bits_q[DW];

  // R7
  rx_disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == RX_IDLE && !done_q));

  // R8
  rx_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (state_q == RX_IDLE && !done_q));

endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  output logic          txd,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [7:0]    ctrl_q,
  output logic [DW-1:0] rx_data,
  output logic          irq
);
  logic [1:0]    fmt_q;
  logic          mp_q, ren_q, tb9_q, rb9_q, tflag_q, rflag_q;
  logic [DW-1:0] rxbuf_q;

  logic          wr_ctrl, wr_tx, nine;
  logic          tx_busy, tx_done;
  logic          rx_done, rx_bit9, rx_stop, rx_accept, rx_filtered;
  logic [DW-1:0] rx_word;

  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_tx   = wr_en && wr_sel;
  assign nine    = fmt_q[1];

  uart9_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .load(wr_tx), .ld_data(wr_data), .ld_b9(tb9_q), .ld_nine(nine),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  uart9_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .en(ren_q), .nine(nine), .rxd(rxd),
    .done(rx_done), .data(rx_word), .bit9(rx_bit9), .stop(rx_stop)
  );

  assign rx_filtered = rx_done && !mp_pass(nine, mp_q, rx_bit9, rx_stop);
  assign rx_accept   = rx_done && !rflag_q && !rx_filtered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= '0;
      mp_q    <= 1'b0;
      ren_q   <= 1'b0;
      tb9_q   <= 1'b0;
      rb9_q   <= 1'b0;
      tflag_q <= 1'b0;
      rflag_q <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        fmt_q   <= wr_data[7:6];
        mp_q    <= wr_data[5];
        ren_q   <= wr_data[4];
        tb9_q   <= wr_data[3];
        rb9_q   <= wr_data[2];
        tflag_q <= wr_data[1];
        rflag_q <= wr_data[0];
      end
      if (tx_done) tflag_q <= 1'b1;
      if (rx_accept) begin
        rflag_q <= 1'b1;
        rxbuf_q <= rx_word;
        rb9_q   <= nine ? rx_bit9 : rx_stop;
      end
    end
  end

  assign ctrl_q  = {fmt_q, mp_q, ren_q, tb9_q, rb9_q, tflag_q, rflag_q};
  assign rx_data = rxbuf_q;
  assign irq     = tflag_q | rflag_q;

  // R5
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tflag_q && !wr_ctrl) |=> tflag_q);

  // R5
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (tflag_q && irq));

  // R9
  rx_overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rflag_q && !wr_ctrl) |=> ($stable(rxbuf_q) && rflag_q));

  // R10
  rx_mp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && nine && mp_q && !rx_bit9 && !wr_ctrl) |=> ($stable(rxbuf_q) && $stable(rflag_q)));

  // R6
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> (rflag_q && irq));

endmodule

// File: tb/uart9_port_test.sv
module uart9_port_test;
  localparam int DW  = 8;
  localparam int OVS = 16;
  localparam int DIV = 4;
  localparam int BIT = OVS * DIV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          rxd = 1'b1;
  logic          txd;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [7:0]    ctrl_q;
  logic [DW-1:0] rx_data;
  logic          irq;
  int            n_chk = 0;
  int            n_fail = 0;
  int            divc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    divc      <= (divc == DIV - 1) ? 0 : divc + 1;
    baud_tick <= (divc == DIV - 1);
  end

  uart9_port #(.DW(DW), .OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ctrl layout: fmt[7:6] mp[5] ren[4] tb9[3] rb9[2] tflag[1] rflag[0]
  function automatic logic [7:0] cfg(input int fmt, input bit mp, input bit ren, input bit tb9);
    return {2'(fmt), mp, ren, tb9, 3'b000};
  endfunction

  task automatic wr(input bit sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sample n bits of txd, first sample pre clocks from now
  task automatic cap(input int n, input int pre, output logic [10:0] bits);
    bits = '1;
    repeat (pre) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i != n - 1) repeat (BIT) @(negedge clk);
    end
  endtask

  function automatic logic [10:0] tx_expect(input logic [7:0] d, input bit nine, input bit b9);
    logic [10:0] e;
    e = '1;
    e[0] = 1'b0;
    for (int i = 0; i < 8; i++) e[i+1] = d[i];
    if (nine) e[9] = b9;
    return e;
  endfunction

  task automatic send(input logic [7:0] d, input bit nine, input bit b9, input bit stp);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (BIT) @(negedge clk);
    end
    rxd = stp;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_reset();
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(ctrl_q === 8'h00, "R1 ctrl", ctrl_q, 0);
    check(irq === 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_tx8();
    logic [10:0] b;
    wr(0, cfg(1, 0, 0, 1));
    check(ctrl_q === 8'h48, "R2 ctrl load", ctrl_q, 8'h48);
    wr(1, 8'hA5);
    cap(10, BIT / 2, b);
    check(b[9:0] === tx_expect(8'hA5, 0, 0)[9:0], "R3 tx 8-bit frame", b, tx_expect(8'hA5, 0, 0));
    repeat (BIT) @(negedge clk);
    check(ctrl_q[1] === 1'b1 && irq === 1'b1, "R5 tx flag set", {ctrl_q[1], irq}, 3);
    repeat (BIT) @(negedge clk);
    check(ctrl_q[1] === 1'b1, "R5 tx flag sticky", ctrl_q[1], 1);
    wr(0, cfg(1, 0, 0, 0));
    check(ctrl_q[1] === 1'b0 && irq === 1'b0, "R5 tx flag cleared", {ctrl_q[1], irq}, 0);
  endtask

  task automatic t_tx9(input bit b9, input logic [7:0] d, input int fmt);
    logic [10:0] b;
    wr(0, cfg(fmt, 0, 0, b9));
    wr(1, d);
    cap(11, BIT / 2, b);
    check(b === tx_expect(d, 1, b9), "R3 tx 9-bit frame", b, tx_expect(d, 1, b9));
    repeat (BIT) @(negedge clk);
    wr(0, cfg(fmt, 0, 0, 0));
  endtask

  task automatic t_tx_busy();
    logic [10:0] b;
    wr(0, cfg(1, 0, 0, 0));
    wr(1, 8'h5A);
    wr(1, 8'hFF);
    cap(10, BIT / 2 - 2, b);
    check(b[9:0] === tx_expect(8'h5A, 0, 0)[9:0], "R4 busy write ignored", b, tx_expect(8'h5A, 0, 0));
    repeat (BIT) @(negedge clk);
    wr(0, cfg(1, 0, 0, 0));
  endtask

  task automatic t_rx8();
    wr(0, cfg(1, 0, 1, 0));
    send(8'hC3, 0, 0, 1);
    check(rx_data === 8'hC3, "R6 rx 8-bit data", rx_data, 8'hC3);
    check(ctrl_q[0] === 1'b1 && irq === 1'b1, "R6 rx flag", {ctrl_q[0], irq}, 3);
    check(ctrl_q[2] === 1'b1, "R6 rx stop captured", ctrl_q[2], 1);
    wr(0, cfg(1, 0, 1, 0));
  endtask

  task automatic t_rx_off();
    wr(0, cfg(1, 0, 0, 0));
    send(8'h11, 0, 0, 1);
    check(ctrl_q[0] === 1'b0 && rx_data === 8'hC3, "R7 rx disabled", {ctrl_q[0], rx_data}, 8'hC3);
  endtask

  task automatic t_glitch();
    wr(0, cfg(1, 0, 1, 0));
    @(negedge clk);
    rxd = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check(ctrl_q[0] === 1'b0, "R8 short pulse discarded", ctrl_q[0], 0);
    send(8'h3C, 0, 0, 1);
    check(ctrl_q[0] === 1'b1 && rx_data === 8'h3C, "R8 frame after glitch", rx_data, 8'h3C);
  endtask

  task automatic t_overrun();
    send(8'h77, 0, 0, 1);
    check(rx_data === 8'h3C && ctrl_q[0] === 1'b1, "R9 overrun keeps data", rx_data, 8'h3C);
    wr(0, cfg(1, 0, 1, 0));
  endtask

  task automatic t_rx9();
    wr(0, cfg(3, 0, 1, 0));
    send(8'h96, 1, 1, 1);
    check(rx_data === 8'h96 && ctrl_q[2] === 1'b1, "R6 rx 9th bit one", {ctrl_q[2], rx_data}, 9'h196);
    wr(0, cfg(2, 0, 1, 0));
    send(8'h69, 1, 0, 1);
    check(rx_data === 8'h69 && ctrl_q[2] === 1'b0 && ctrl_q[0] === 1'b1, "R6 rx 9th bit zero",
          {ctrl_q[2], rx_data}, 9'h069);
    wr(0, cfg(2, 0, 1, 0));
  endtask

  task automatic t_mp9();
    wr(0, cfg(2, 1, 1, 0));
    send(8'hE1, 1, 0, 1);
    check(ctrl_q[0] === 1'b0 && rx_data === 8'h69, "R10 data frame filtered", rx_data, 8'h69);
    send(8'h2B, 1, 1, 1);
    check(ctrl_q[0] === 1'b1 && rx_data === 8'h2B, "R10 address frame accepted", rx_data, 8'h2B);
    wr(0, cfg(2, 1, 1, 0));
  endtask

  task automatic t_mp8();
    wr(0, cfg(1, 1, 1, 0));
    send(8'h4D, 0, 0, 0);
    check(ctrl_q[0] === 1'b0 && rx_data === 8'h2B, "R11 bad stop rejected", rx_data, 8'h2B);
    send(8'hD4, 0, 0, 1);
    check(ctrl_q[0] === 1'b1 && rx_data === 8'hD4, "R11 good stop accepted", rx_data, 8'hD4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx8();
    t_tx9(1, 8'h3E, 2);
    t_tx9(0, 8'hC1, 3);
    t_tx_busy();
    t_rx8();
    t_rx_off();
    t_glitch();
    t_overrun();
    t_rx9();
    t_mp9();
    t_mp8();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule